// File: doc/BRIEF.md
# Private Peripheral Window Decoder

The block sits between one requester and the contents of a 1 MiB private peripheral address window. Each request carries a window offset, a write flag, write data, a byte count, a privileged/user flag and a secure/non-secure flag. The block routes the request to one of three places: the system-register port, the tick-timer port, or a built-in default responder that answers without any downstream traffic. Sub-regions overlap by priority. The tick-timer range sits inside the system-register range and wins there. The system-register range wins over the default responder.

When the security option is built in, a second 4 KiB window forwards secure accesses to the system-register port as non-secure accesses. Non-secure accesses to that window are answered locally.

The requester side uses valid/ready. The requester raises `req_valid` and holds every request field stable until `req_ready` is high at a clock edge. The selected downstream port sees the request directly and may stall it by keeping its ready low. `req_ready` follows that port's ready, and is high at once for locally answered requests. A downstream port returns its read data and error flag in the same cycle as its ready. One cycle after the handshake, `rsp_valid` pulses for one cycle with the registered data and error. The response has no back-pressure, so the requester must take it in that cycle.

Top module: `ppb_decoder`

## Requirements
- R1: While reset is held and after it is released with no request, `rsp_valid`, `sys_valid` and `tck_valid` are 0.
- R2: Offsets 0x0E000–0x0EFFF outside the tick range go to the system-register port. `sys_addr` is the low 12 offset bits, and the privilege, secure, write and size fields are passed through unchanged.
- R3: Offsets 0x0E010–0x0E0FF go only to the tick-timer port, with `tck_addr` set to the low 12 offset bits. At most one downstream valid is ever high.
- R4: A privileged access to any offset no region claims is answered locally with read data 0 and no error. A write there reaches no port.
- R5: A user access to an unclaimed offset is answered locally with an error.
- R6: With `SEC_EXT`=1, a secure access to 0x2E000–0x2EFFF goes to the system-register port at the same low 12 bits, with `sys_secure` forced to 0. This includes the low 12 bits 0x010–0x0FF, which are not sent to the tick-timer port.
- R7: A non-secure access to 0x2E000–0x2EFFF is answered locally: privileged gives data 0 and no error, user gives an error.
- R8: With `SEC_EXT`=0, the range 0x2E000–0x2EFFF is treated as unclaimed and handled as in R4/R5.
- R9: A byte count other than 1, 2, 4 or 8 is answered locally with an error and data 0, at any privilege, and no port sees it.
- R10: The request is held until the selected port's ready is high. `req_ready` is low in every cycle before that. `rsp_valid` is high exactly in the cycle after each handshake.
- R11: The response carries the selected port's read data and error flag as they were at the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 20 | Offset within the window |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 64 | Write data |
| req_size | input | 4 | Byte count |
| req_priv | input | 1 | 1 = privileged |
| req_secure | input | 1 | 1 = secure |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Error response |
| sys_valid | output | 1 | System-register request |
| sys_ready | input | 1 | System-register accept, data valid |
| sys_addr | output | 12 | Offset in register block |
| sys_write | output | 1 | Write flag |
| sys_wdata | output | 64 | Write data |
| sys_size | output | 4 | Byte count |
| sys_priv | output | 1 | Privilege |
| sys_secure | output | 1 | Security state as seen by the registers |
| sys_rdata | input | 64 | Read data |
| sys_err | input | 1 | Error flag |
| tck_valid | output | 1 | Tick-timer request |
| tck_ready | input | 1 | Tick-timer accept, data valid |
| tck_addr | output | 12 | Offset in register block |
| tck_write | output | 1 | Write flag |
| tck_wdata | output | 64 | Write data |
| tck_size | output | 4 | Byte count |
| tck_priv | output | 1 | Privilege |
| tck_secure | output | 1 | Security state |
| tck_rdata | input | 64 | Read data |
| tck_err | input | 1 | Error flag |

## Verification
The bench probes both edges of each overlapping range: 0x0E00C against 0x0E010, 0x0E0FF against 0x0E100, and 0x0EFFF against 0x0F000. This separates the tick-timer priority from the enclosing register region and the default fill.

Alias accesses are sent with each combination of security and privilege. This shows the forced non-secure attribute, the absence of tick priority inside the alias, and the local read-as-zero or error answers. A second instance built without the security option shows that the alias range becomes unclaimed.

Illegal byte counts, downstream stalls of zero to three cycles, and a downstream error confirm that back-pressure and responses are passed through faithfully.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;
  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_SYS   = 2'd1,
    TGT_TICK  = 2'd2
  } ppb_tgt_e;
endpackage

// File: rtl/ppb_region_decode.sv
`timescale 1ns/1ps
module ppb_region_decode
  import ppb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WIN_W  = 12,
  parameter int SIZE_W = 4,
  parameter int MAX_BYTES = 8,
  parameter bit SEC_EXT = 1'b1,
  parameter logic [ADDR_W-1:0] SYS_BASE   = 'h0E000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 'h2E000,
  parameter logic [WIN_W-1:0]  TICK_LO    = 'h010,
  parameter logic [WIN_W-1:0]  TICK_HI    = 'h0FF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              secure,
  output ppb_tgt_e          tgt,
  output logic [WIN_W-1:0]  fwd_off,
  output logic              fwd_secure,
  output logic              bad_size
);
  localparam int PAGE_W = ADDR_W - WIN_W;

  logic in_sys, in_alias, in_tick;
  logic [WIN_W-1:0] off;

  assign off      = addr[WIN_W-1:0];
  assign in_sys   = (addr[ADDR_W-1:WIN_W] == SYS_BASE[ADDR_W-1:WIN_W]);
  assign in_tick  = in_sys && (off >= TICK_LO) && (off <= TICK_HI);
  assign bad_size = !$onehot(size) || (32'(size) > MAX_BYTES);

  generate
    if (SEC_EXT) begin : g_alias
      logic [PAGE_W-1:0] alias_page;
      assign alias_page = ALIAS_BASE[ADDR_W-1:WIN_W];
      assign in_alias   = (addr[ADDR_W-1:WIN_W] == alias_page);
    end else begin : g_no_alias
      assign in_alias = 1'b0;
    end
  endgenerate

  always_comb begin
    tgt        = TGT_LOCAL;
    fwd_off    = off;
    fwd_secure = secure;
    if (bad_size) begin
      tgt = TGT_LOCAL;
    end else if (in_tick) begin
      tgt = TGT_TICK;
    end else if (in_sys) begin
      tgt = TGT_SYS;
    end else if (in_alias && secure) begin
      tgt        = TGT_SYS;
      fwd_secure = 1'b0;
    end
  end
endmodule

// File: rtl/ppb_rsp_reg.sv
`timescale 1ns/1ps
module ppb_rsp_reg
  import ppb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs,
  input  ppb_tgt_e          tgt,
  input  logic              local_err,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic              sys_err,
  input  logic [DATA_W-1:0] tck_rdata,
  input  logic              tck_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= hs;
      if (hs) begin
        unique case (tgt)
          TGT_SYS: begin
            rsp_rdata <= sys_rdata;
            rsp_err   <= sys_err;
          end
          TGT_TICK: begin
            rsp_rdata <= tck_rdata;
            rsp_err   <= tck_err;
          end
          default: begin
            rsp_rdata <= '0;
            rsp_err   <= local_err;
          end
        endcase
      end
    end
  end

  AST_RSP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> !rsp_valid); // R10
endmodule

// File: rtl/ppb_decoder.sv
`timescale 1ns/1ps
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int WIN_W  = 12,
  parameter bit SEC_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_priv,
  input  logic              req_secure,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              sys_valid,
  input  logic              sys_ready,
  output logic [WIN_W-1:0]  sys_addr,
  output logic              sys_write,
  output logic [DATA_W-1:0] sys_wdata,
  output logic [SIZE_W-1:0] sys_size,
  output logic              sys_priv,
  output logic              sys_secure,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic              sys_err,
  output logic              tck_valid,
  input  logic              tck_ready,
  output logic [WIN_W-1:0]  tck_addr,
  output logic              tck_write,
  output logic [DATA_W-1:0] tck_wdata,
  output logic [SIZE_W-1:0] tck_size,
  output logic              tck_priv,
  output logic              tck_secure,
  input  logic [DATA_W-1:0] tck_rdata,
  input  logic              tck_err
);
  ppb_tgt_e         tgt;
  logic [WIN_W-1:0] fwd_off;
  logic             fwd_secure, bad_size, local_err, hs;

  ppb_region_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .SIZE_W(SIZE_W), .SEC_EXT(SEC_EXT)
  ) u_dec (
    .addr(req_addr), .size(req_size), .secure(req_secure),
    .tgt(tgt), .fwd_off(fwd_off), .fwd_secure(fwd_secure), .bad_size(bad_size)
  );

  assign sys_valid  = req_valid && (tgt == TGT_SYS);
  assign sys_addr   = fwd_off;
  assign sys_write  = req_write;
  assign sys_wdata  = req_wdata;
  assign sys_size   = req_size;
  assign sys_priv   = req_priv;
  assign sys_secure = fwd_secure;

  assign tck_valid  = req_valid && (tgt == TGT_TICK);
  assign tck_addr   = fwd_off;
  assign tck_write  = req_write;
  assign tck_wdata  = req_wdata;
  assign tck_size   = req_size;
  assign tck_priv   = req_priv;
  assign tck_secure = req_secure;

  always_comb begin
    unique case (tgt)
      TGT_SYS:  req_ready = sys_ready;
      TGT_TICK: req_ready = tck_ready;
      default:  req_ready = 1'b1;
    endcase
  end

  assign hs        = req_valid && req_ready;
  assign local_err = bad_size || !req_priv;

  ppb_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .hs(hs), .tgt(tgt), .local_err(local_err),
    .sys_rdata(sys_rdata), .sys_err(sys_err),
    .tck_rdata(tck_rdata), .tck_err(tck_err),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_valid && tck_valid)); // R3
  AST_BADSIZE_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !$onehot(req_size)) |-> (!sys_valid && !tck_valid)); // R9
  AST_ALIAS_NONSEC: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && (req_addr[ADDR_W-1:WIN_W] != 'h0E)) |-> !sys_secure); // R6
  AST_USER_LOCAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_priv && !sys_valid && !tck_valid) |=> rsp_err); // R5
endmodule

// File: tb/tb_ppb_decoder.sv
`timescale 1ns/1ps
module tb_ppb_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
  logic [19:0] req_addr = '0;
  logic [63:0] req_wdata = 64'h1122_3344_5566_7788;
  logic [3:0]  req_size = 4'd4;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        sys_valid, sys_ready, sys_write, sys_priv, sys_secure;
  logic [11:0] sys_addr, tck_addr;
  logic [63:0] sys_wdata, tck_wdata, sys_rdata, tck_rdata;
  logic [3:0]  sys_size, tck_size;
  logic        tck_valid, tck_ready, tck_write, tck_priv, tck_secure;
  logic        sys_err_f = 1'b0;

  int sys_lat = 0, tck_lat = 0;
  int scnt, tcnt;
  int checks = 0, fails = 0;

  assign sys_ready = sys_valid && (scnt >= sys_lat);
  assign tck_ready = tck_valid && (tcnt >= tck_lat);
  assign sys_rdata = {52'hA5A5A5A5A5A5A, sys_addr};
  assign tck_rdata = {52'h3C3C3C3C3C3C3, tck_addr};

  always_ff @(posedge clk) begin
    scnt <= (sys_valid && !sys_ready) ? scnt + 1 : 0;
    tcnt <= (tck_valid && !tck_ready) ? tcnt + 1 : 0;
  end

  ppb_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_priv(req_priv), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_addr(sys_addr),
    .sys_write(sys_write), .sys_wdata(sys_wdata), .sys_size(sys_size),
    .sys_priv(sys_priv), .sys_secure(sys_secure), .sys_rdata(sys_rdata),
    .sys_err(sys_err_f),
    .tck_valid(tck_valid), .tck_ready(tck_ready), .tck_addr(tck_addr),
    .tck_write(tck_write), .tck_wdata(tck_wdata), .tck_size(tck_size),
    .tck_priv(tck_priv), .tck_secure(tck_secure), .tck_rdata(tck_rdata),
    .tck_err(1'b0)
  );

  logic        nv_valid = 1'b0, nv_ready, nv_rsp_valid, nv_rsp_err;
  logic [63:0] nv_rsp_rdata, nv_sys_wdata, nv_tck_wdata;
  logic        nv_sys_valid, nv_sys_write, nv_sys_priv, nv_sys_secure;
  logic        nv_tck_valid, nv_tck_write, nv_tck_priv, nv_tck_secure;
  logic [11:0] nv_sys_addr, nv_tck_addr;
  logic [3:0]  nv_sys_size, nv_tck_size;

  ppb_decoder #(.SEC_EXT(1'b0)) dut_nosec (
    .clk(clk), .rst_n(rst_n), .req_valid(nv_valid), .req_ready(nv_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_size(req_size), .req_priv(req_priv), .req_secure(req_secure),
    .rsp_valid(nv_rsp_valid), .rsp_rdata(nv_rsp_rdata), .rsp_err(nv_rsp_err),
    .sys_valid(nv_sys_valid), .sys_ready(1'b1), .sys_addr(nv_sys_addr),
    .sys_write(nv_sys_write), .sys_wdata(nv_sys_wdata), .sys_size(nv_sys_size),
    .sys_priv(nv_sys_priv), .sys_secure(nv_sys_secure), .sys_rdata(64'hFFFF),
    .sys_err(1'b0),
    .tck_valid(nv_tck_valid), .tck_ready(1'b1), .tck_addr(nv_tck_addr),
    .tck_write(nv_tck_write), .tck_wdata(nv_tck_wdata), .tck_size(nv_tck_size),
    .tck_priv(nv_tck_priv), .tck_secure(nv_tck_secure), .tck_rdata(64'hEEEE),
    .tck_err(1'b0)
  );

  typedef struct { logic [63:0] rdata; logic err; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected response per observed pulse
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
        check(rsp_err == e.err, e.tag, "err", {63'd0, rsp_err}, {63'd0, e.err});
      end
    end
  end

  // Driver: tgt 0 local, 1 system-register port, 2 tick port
  task automatic issue(input logic [19:0] a, input logic wr, input logic [3:0] sz,
                       input logic pv, input logic sc, input int tgt,
                       input logic [11:0] eoff, input logic esec, input int ewait,
                       input logic [63:0] erd, input logic eerr, input string tag);
    exp_t e;
    int n;
    e.rdata = erd; e.err = eerr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_addr = a; req_write = wr; req_size = sz; req_priv = pv; req_secure = sc;
    req_valid = 1'b1;
    n = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; n++;
    end
    check(n == ewait, tag, "stall cycles", 64'(n), 64'(ewait));
    check(sys_valid == (tgt == 1) && tck_valid == (tgt == 2), tag, "port select",
          {62'd0, tck_valid, sys_valid}, 64'(tgt == 1 ? 1 : (tgt == 2 ? 2 : 0)));
    if (tgt == 1) begin
      check(sys_addr == eoff && sys_secure == esec && sys_write == wr && sys_priv == pv
            && sys_size == sz, tag, "sys fields", {51'd0, sys_secure, sys_addr},
            {51'd0, esec, eoff});
    end
    if (tgt == 2) begin
      check(tck_addr == eoff && tck_write == wr && tck_secure == sc, tag, "tick fields",
            {52'd0, tck_addr}, {52'd0, eoff});
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  localparam logic [63:0] SYSD = {52'hA5A5A5A5A5A5A, 12'h000};
  localparam logic [63:0] TCKD = {52'h3C3C3C3C3C3C3, 12'h000};

  initial begin
    #(8 * 150000);
    check(1'b0, "R10", "watchdog expired", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && !sys_valid && !tck_valid, "R1", "outputs in reset",
          {61'd0, rsp_valid, sys_valid, tck_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!rsp_valid && !sys_valid && !tck_valid, "R1", "outputs idle after reset",
          {61'd0, rsp_valid, sys_valid, tck_valid}, 64'd0);

    // R2 main register region, varied attributes and stalls
    issue(20'h0E004, 0, 4'd4, 1, 1, 1, 12'h004, 1, 0, SYSD | 64'h004, 0, "R2");
    sys_lat = 2;
    issue(20'h0ED08, 1, 4'd8, 0, 0, 1, 12'hD08, 0, 2, SYSD | 64'hD08, 0, "R10/R2");
    sys_lat = 0;
    issue(20'h0E00C, 0, 4'd1, 1, 0, 1, 12'h00C, 0, 0, SYSD | 64'h00C, 0, "R2 below tick");
    issue(20'h0E100, 0, 4'd2, 1, 1, 1, 12'h100, 1, 0, SYSD | 64'h100, 0, "R2 above tick");
    issue(20'h0EFFF, 0, 4'd1, 1, 1, 1, 12'hFFF, 1, 0, SYSD | 64'hFFF, 0, "R2 top");
    // R3 tick region edges
    tck_lat = 1;
    issue(20'h0E010, 0, 4'd4, 1, 1, 2, 12'h010, 1, 1, TCKD | 64'h010, 0, "R3 low");
    tck_lat = 3;
    issue(20'h0E0FF, 1, 4'd1, 0, 0, 2, 12'h0FF, 0, 3, TCKD | 64'h0FF, 0, "R3/R10 high");
    tck_lat = 0;
    // R4/R5 default responder
    issue(20'h01000, 0, 4'd4, 1, 1, 0, 12'h0, 0, 0, 64'd0, 0, "R4 read");
    issue(20'h0F000, 1, 4'd4, 1, 0, 0, 12'h0, 0, 0, 64'd0, 0, "R4 write");
    issue(20'h0DFFF, 0, 4'd1, 0, 1, 0, 12'h0, 0, 0, 64'd0, 1, "R5 user");
    issue(20'hFFFF8, 1, 4'd8, 0, 0, 0, 12'h0, 0, 0, 64'd0, 1, "R5 user write");
    // R6 alias secure forwarding, no tick priority inside
    issue(20'h2E004, 0, 4'd4, 1, 1, 1, 12'h004, 0, 0, SYSD | 64'h004, 0, "R6");
    sys_lat = 1;
    issue(20'h2E020, 1, 4'd4, 0, 1, 1, 12'h020, 0, 1, SYSD | 64'h020, 0, "R6 tick offset");
    sys_lat = 0;
    // R7 alias non-secure
    issue(20'h2E004, 0, 4'd4, 1, 0, 0, 12'h0, 0, 0, 64'd0, 0, "R7 priv");
    issue(20'h2EFF0, 1, 4'd4, 0, 0, 0, 12'h0, 0, 0, 64'd0, 1, "R7 user");
    // R9 sizes
    issue(20'h0E004, 0, 4'd3, 1, 1, 0, 12'h0, 0, 0, 64'd0, 1, "R9 size3");
    issue(20'h0E020, 1, 4'd0, 1, 1, 0, 12'h0, 0, 0, 64'd0, 1, "R9 size0");
    // R11 downstream error passes through
    sys_err_f = 1'b1;
    issue(20'h0E400, 0, 4'd4, 1, 1, 1, 12'h400, 1, 0, SYSD | 64'h400, 1, "R11");
    sys_err_f = 1'b0;

    // R8 instance without security option
    @(negedge clk);
    req_addr = 20'h2E004; req_secure = 1; req_priv = 1; req_size = 4'd4; req_write = 0;
    nv_valid = 1'b1; #1;
    check(nv_ready && !nv_sys_valid && !nv_tck_valid, "R8", "alias unclaimed",
          {61'd0, nv_ready, nv_sys_valid, nv_tck_valid}, 64'd4);
    @(posedge clk); #1; nv_valid = 1'b0;
    @(negedge clk);
    check(nv_rsp_valid && nv_rsp_rdata == 64'd0 && !nv_rsp_err, "R8", "priv response",
          nv_rsp_rdata, 64'd0);
    @(negedge clk);
    req_priv = 0; nv_valid = 1'b1;
    @(posedge clk); #1; nv_valid = 1'b0;
    @(negedge clk);
    check(nv_rsp_valid && nv_rsp_err, "R8", "user error", {63'd0, nv_rsp_err}, 64'd1);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10", "missing responses", 64'(sb.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule